// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Divider

This block derives the bit clock of a synchronous serial port from a faster system clock. Two divisors sit in series. The first is an even prescaler. The second is a rate divider of (1 + rate value). Together they give an output period of exactly prescaler × (1 + rate) system clocks, with equal high and low times. A shift engine running on the system clock uses the single-cycle rise and fall strobes and never samples the generated clock directly.

The prescaler's least significant bit is discarded. An even value of zero is rejected. Any setting whose output frequency would exceed the configured ceiling is also rejected. A rejected setting raises the error flag, and the clock stays at its idle level. Settings are taken from the inputs only while the generator is idle. Anything presented during a run waits until the run ends, so a phase is never cut short. When enable drops, the current full period runs to completion before the clock parks.

Top module: `sclk_gen`

## Requirements
- R1: With a legal setting and enable high, the time between consecutive rising strobes is (prescaler with bit 0 cleared) × (1 + rate) system clocks.
- R2: High time and low time of the serial clock are each (prescaler with bit 0 cleared)/2 × (1 + rate) system clocks.
- R3: Prescaler bit 0 has no effect: an odd value behaves as the even value one below it (3 acts as 2, 5 acts as 4).
- R4: A prescaler of 0 or 1 is illegal: the error output goes high, the serial clock stays at its idle level (0) and no strobe appears, even with enable high.
- R5: A setting whose output exceeds MAX_SCLK_HZ for SYS_CLK_HZ is illegal and is handled as in R4. With the defaults (80 MHz in, 25 MHz limit), prescaler 2 with rate 0 is illegal, while prescaler 2 with rate 1 and prescaler 4 with rate 0 are legal.
- R6: rise_o and fall_o are one-cycle pulses, asserted in the first cycle in which sclk_o shows its new level, and never together.
- R7: Input changes made while the clock runs do not affect the running period or the error output. They take effect at the next start from idle.
- R8: After enable falls, the clock finishes its current full period, ends at the idle level and then produces no further strobes.
- R9: In and just after reset, sclk_o, rise_o, fall_o and cfg_err_o are 0. The reset setting is prescaler 2, rate 9 (4 MHz at 80 MHz).
- R10: The error output clears one cycle after a legal setting is presented while idle, and with enable high the clock then starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run request for the serial clock |
| psc_i | input | PSC_W | Prescaler value; bit 0 is ignored |
| rate_i | input | RATE_W | Rate value; the second stage divides by rate+1 |
| sclk_o | output | 1 | Generated serial clock, idle level IDLE_LVL |
| rise_o | output | 1 | One-cycle strobe on a rising serial clock edge |
| fall_o | output | 1 | One-cycle strobe on a falling serial clock edge |
| cfg_err_o | output | 1 | Active setting is illegal |

## Verification
A corrupted inner or outer counter changes the half-period length. This shows up at the very next strobe as a high or low time that differs from (prescaler/2)×(1+rate). A stale or wrongly latched setting shows up in the first full period after the next start. It also shows up in cfg_err_o one cycle after an idle load. A wrong run/idle state shows up as a strobe while the error flag is high, as a clock that does not park within one period of enable falling, or as an extra strobe after the clock has parked.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} sclk_st_e;

  // Output frequency sys/div must not exceed mx.
  function automatic logic div_ok(input longint unsigned div,
                                  input longint unsigned sys,
                                  input longint unsigned mx);
    return (div != 0) && (div * mx >= sys);
  endfunction
endpackage

// File: rtl/sclk_cfg.sv
module sclk_cfg #(
  parameter int unsigned     PSC_W      = 8,
  parameter int unsigned     RATE_W     = 8,
  parameter longint unsigned SYS_CLK_HZ = 80_000_000,
  parameter longint unsigned MAX_HZ     = 25_000_000,
  parameter int unsigned     DEF_PSC    = 2,
  parameter int unsigned     DEF_RATE   = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic [PSC_W-2:0]  half_o,
  output logic [RATE_W-1:0] rate_o,
  output logic              in_ok_o,
  output logic              err_o
);
  import sclk_pkg::*;

  localparam int unsigned HW = PSC_W - 1;
  localparam longint unsigned DEF_DIV =
    longint'(DEF_PSC / 2 * 2) * (longint'(DEF_RATE) + 1);
  localparam logic DEF_ERR = !div_ok(DEF_DIV, SYS_CLK_HZ, MAX_HZ);
  localparam logic [HW-1:0]     DEF_HALF = HW'(DEF_PSC / 2);
  localparam logic [RATE_W-1:0] DEF_R    = RATE_W'(DEF_RATE);

  logic [HW-1:0] in_half;
  longint unsigned in_div;

  assign in_half = psc_i[PSC_W-1:1];
  assign in_div  = (longint'(in_half) * 2) * (longint'(rate_i) + 1);
  assign in_ok_o = div_ok(in_div, SYS_CLK_HZ, MAX_HZ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_o <= DEF_HALF;
      rate_o <= DEF_R;
      err_o  <= DEF_ERR;
    end else if (load_i) begin
      half_o <= in_half;
      rate_o <= rate_i;
      err_o  <= !in_ok_o;
    end
  end
endmodule

// File: rtl/sclk_tick.sv
module sclk_tick #(
  parameter int unsigned HW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic [HW-1:0] half_i,
  output logic          tick_o
);
  logic [HW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == half_i - HW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + HW'(1);
  end
endmodule

// File: rtl/sclk_phase.sv
module sclk_phase #(
  parameter int unsigned RW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [RW-1:0] rate_i,
  output logic          toggle_o
);
  logic [RW-1:0] ph_q;

  assign toggle_o = tick_i && (ph_q == rate_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ph_q <= '0;
    else if (!run_i || toggle_o) ph_q <= '0;
    else if (tick_i)             ph_q <= ph_q + RW'(1);
  end
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen #(
  parameter int unsigned     PSC_W       = 8,
  parameter int unsigned     RATE_W      = 8,
  parameter longint unsigned SYS_CLK_HZ  = 80_000_000,
  parameter longint unsigned MAX_SCLK_HZ = 25_000_000,
  parameter int unsigned     DEF_PSC     = 2,
  parameter int unsigned     DEF_RATE    = 9,
  parameter bit              IDLE_LVL    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSC_W-1:0]  psc_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              sclk_o,
  output logic              rise_o,
  output logic              fall_o,
  output logic              cfg_err_o
);
  import sclk_pkg::*;

  localparam int unsigned HW = PSC_W - 1;

  sclk_st_e          st_q, st_d;
  logic              running, load, start, finish;
  logic [HW-1:0]     cfg_half;
  logic [RATE_W-1:0] cfg_rate;
  logic              in_ok, tick, toggle;
  logic              act_q, lead, trail;
  logic              rise_q, fall_q;

  assign running = (st_q == ST_RUN);
  assign load    = !running;

  sclk_cfg #(
    .PSC_W(PSC_W), .RATE_W(RATE_W), .SYS_CLK_HZ(SYS_CLK_HZ),
    .MAX_HZ(MAX_SCLK_HZ), .DEF_PSC(DEF_PSC), .DEF_RATE(DEF_RATE)
  ) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load),
    .psc_i(psc_i), .rate_i(rate_i),
    .half_o(cfg_half), .rate_o(cfg_rate),
    .in_ok_o(in_ok), .err_o(cfg_err_o)
  );

  sclk_tick #(.HW(HW)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(running),
    .half_i(cfg_half), .tick_o(tick)
  );

  sclk_phase #(.RW(RATE_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(running),
    .tick_i(tick), .rate_i(cfg_rate), .toggle_o(toggle)
  );

  // act_q: 0 = idle level, 1 = active level
  assign lead   = toggle && !act_q;
  assign trail  = toggle &&  act_q;
  assign start  = !running && en_i && in_ok;
  assign finish = trail && !en_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (start)  st_d = ST_RUN;
      ST_RUN:  if (finish) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      act_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (toggle) act_q <= !act_q;
    end
  end

  generate
    if (IDLE_LVL == 1'b0) begin : g_idle_lo
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rise_q <= 1'b0;
          fall_q <= 1'b0;
        end else begin
          rise_q <= lead;
          fall_q <= trail;
        end
      end
    end else begin : g_idle_hi
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          rise_q <= 1'b0;
          fall_q <= 1'b0;
        end else begin
          rise_q <= trail;
          fall_q <= lead;
        end
      end
    end
  endgenerate

  assign sclk_o = act_q ^ IDLE_LVL;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
endmodule

// File: rtl/sclk_gen_chk.sv
module sclk_gen_chk #(
  parameter int unsigned     HW          = 7,
  parameter int unsigned     RATE_W      = 8,
  parameter longint unsigned SYS_CLK_HZ  = 80_000_000,
  parameter longint unsigned MAX_SCLK_HZ = 25_000_000,
  parameter bit              IDLE_LVL    = 1'b0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sclk_o,
  input logic              rise_o,
  input logic              fall_o,
  input logic              cfg_err_o,
  input logic              running_i,
  input logic [HW-1:0]     half_i,
  input logic [RATE_W-1:0] rate_i
);
  logic [31:0] lvl_cnt;

  // cycles the previous level was held, sampled at a strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                lvl_cnt <= 32'hFFFF_FFFF;
    else if (rise_o || fall_o)  lvl_cnt <= 32'd1;
    else if (lvl_cnt != 32'hFFFF_FFFF) lvl_cnt <= lvl_cnt + 32'd1;
  end

  a_r6_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_o && fall_o));
  a_r6_rise_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (sclk_o && !$past(sclk_o)));
  a_r6_fall_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |-> (!sclk_o && $past(sclk_o)));
  a_r6_edge_marked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o != $past(sclk_o)) |-> (rise_o || fall_o));
  a_r4_err_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> (sclk_o == IDLE_LVL && !rise_o && !fall_o));
  a_r7_cfg_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (running_i && $past(running_i)) |-> ($stable(half_i) && $stable(rate_i) && $stable(cfg_err_o)));
  a_r8_park_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_i |-> (sclk_o == IDLE_LVL));
  a_r5_max_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o || fall_o) |-> (longint'(lvl_cnt) * 2 * MAX_SCLK_HZ >= SYS_CLK_HZ));
endmodule

bind sclk_gen sclk_gen_chk #(
  .HW(PSC_W - 1), .RATE_W(RATE_W), .SYS_CLK_HZ(SYS_CLK_HZ),
  .MAX_SCLK_HZ(MAX_SCLK_HZ), .IDLE_LVL(IDLE_LVL)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .rise_o(rise_o),
  .fall_o(fall_o), .cfg_err_o(cfg_err_o), .running_i(running),
  .half_i(cfg_half), .rate_i(cfg_rate)
);

// File: tb/sclk_gen_tb.sv
module sclk_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] psc = 8'd2;
  logic [7:0] rate = 8'd9;
  logic       sclk, rise, fall, err;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sclk_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .psc_i(psc), .rate_i(rate),
    .sclk_o(sclk), .rise_o(rise), .fall_o(fall), .cfg_err_o(err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // samples after negedges until the strobe; returns count or -1
  task automatic wait_strobe(input bit want_rise, output int n);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (want_rise ? rise : fall) break;
      if (n > 70000) begin n = -1; break; end
    end
  endtask

  // watch for n cycles; count strobes and non-idle samples
  task automatic quiet(input string req, input int cycles);
    int hits;
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rise || fall || sclk) hits++;
    end
    chk(req, "activity while quiet", hits, 0);
  endtask

  task automatic stop_clk(input string req);
    int n;
    @(negedge clk);
    en = 1'b0;
    wait_strobe(1'b0, n);
    chk(req, "final fall seen", int'(n > 0), 1);
    quiet(req, 40);
  endtask

  task automatic measure(input string req, input logic [7:0] p, input logic [7:0] r, input int h);
    int n;
    @(negedge clk);
    psc = p; rate = r; en = 1'b1;
    wait_strobe(1'b1, n);
    chk(req, "first rise seen", int'(n > 0), 1);
    wait_strobe(1'b0, n);
    chk({req, " R2"}, "high time", n, h);
    wait_strobe(1'b1, n);
    chk({req, " R2"}, "low time", n, h);
    wait_strobe(1'b1, n);
    chk({req, " R1"}, "period", n, 2 * h);
    chk(req, "err low", int'(err), 0);
    stop_clk({req, " R8"});
  endtask

  task automatic t_reset;
    chk("R9", "sclk in reset", int'(sclk), 0);
    chk("R9", "strobes in reset", int'(rise | fall), 0);
    chk("R9", "err in reset", int'(err), 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R9", "err after reset", int'(err), 0);
    chk("R9", "sclk after reset", int'(sclk), 0);
    measure("R9 default 4MHz", 8'd2, 8'd9, 10);
  endtask

  task automatic t_points;
    measure("R1 p4r1", 8'd4, 8'd1, 4);
    measure("R1 p2r3", 8'd2, 8'd3, 4);
    measure("R1 p4r19", 8'd4, 8'd19, 40);
    measure("R1 p2r15", 8'd2, 8'd15, 16);
    measure("R5 p4r0 legal", 8'd4, 8'd0, 2);
    measure("R5 p2r1 legal", 8'd2, 8'd1, 2);
    measure("R1 p254r5", 8'd254, 8'd5, 762);
  endtask

  task automatic t_odd;
    measure("R3 p3r3", 8'd3, 8'd3, 4);
    measure("R3 p5r0", 8'd5, 8'd0, 2);
  endtask

  task automatic t_illegal(input string req, input logic [7:0] p, input logic [7:0] r);
    @(negedge clk);
    psc = p; rate = r; en = 1'b1;
    @(negedge clk);
    chk(req, "err set", int'(err), 1);
    quiet(req, 100);
    chk(req, "err held", int'(err), 1);
  endtask

  task automatic t_bad;
    int n;
    t_illegal("R4 p0", 8'd0, 8'd9);
    t_illegal("R4 p1", 8'd1, 8'd3);
    t_illegal("R5 p2r0", 8'd2, 8'd0);
    @(negedge clk);
    psc = 8'd2; rate = 8'd9;
    @(negedge clk);
    chk("R10", "err cleared", int'(err), 0);
    wait_strobe(1'b1, n);
    chk("R10", "starts after clear", int'(n > 0), 1);
    stop_clk("R10 R8");
  endtask

  task automatic t_defer;
    int n;
    @(negedge clk);
    psc = 8'd2; rate = 8'd9; en = 1'b1;
    wait_strobe(1'b1, n);
    @(negedge clk);
    chk("R6", "rise one cycle", int'(rise), 0);
    chk("R6", "level held after rise", int'(sclk), 1);
    psc = 8'd4; rate = 8'd19;
    wait_strobe(1'b0, n);
    chk("R7", "high time unchanged", n + 1, 10);
    @(negedge clk);
    chk("R6", "fall one cycle", int'(fall), 0);
    psc = 8'd0;
    wait_strobe(1'b1, n);
    chk("R7", "low time unchanged", n + 1, 10);
    chk("R7", "err ignores pending illegal", int'(err), 0);
    psc = 8'd4;
    stop_clk("R8 mid");
    measure("R7 applied at restart", 8'd4, 8'd19, 40);
  endtask

  task automatic t_stop_low;
    int n;
    @(negedge clk);
    psc = 8'd2; rate = 8'd9; en = 1'b1;
    wait_strobe(1'b0, n);
    @(negedge clk);
    en = 1'b0;
    wait_strobe(1'b1, n);
    chk("R8", "rise completes period", n + 1, 10);
    wait_strobe(1'b0, n);
    chk("R8", "fall completes period", n, 10);
    quiet("R8", 60);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_points();
    t_odd();
    t_bad();
    t_defer();
    t_stop_low();
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule